// File: doc/BRIEF.md
# Attribute-Typed Configuration Register Bank

This block holds a small set of 32-bit configuration words. Every bit has a fixed access attribute, set by a parameter. The attribute decides how a software write, a hardware update and each of the two resets affect that bit. Software reaches the bank through a simple synchronous port that carries a word offset, four byte-lane write enables, write data and registered read data. Logic elsewhere on the chip uses per-bit hardware inputs to raise event bits and to load read-only status values.

There are two reset inputs. The hard reset `hrst_n` returns every ordinary bit to its default value. The power-good input `por_n` returns every bit to its default, including the sticky bits that keep their value through a hard reset. Write-once bits are protected by one lock flag for each byte lane. A lane whose bits are all sticky write-once keeps its lock until power-good is lost.

The default parameter set repeats a four-word layout. The requirements below use the following attribute codes (`attr_e`): 0 reserved, 1 read-only, 2 read/write, 3 write-once, 4 write-one-to-clear, 5 sticky read-only, 6 sticky read/write, 7 sticky write-one-to-clear, 8 sticky write-once.

Top module: `cab_attr_bank`

## Requirements
- R1: A read-only bit (offset 3, bits 23:0; default 0x5A00C3) ignores all software writes. It loads `hw_val` only when its `hw_load` bit is high. A hard reset returns the non-sticky part, bits 15:0, to its default.
- R2: A read/write bit (offset 0, default 0x12345678) takes the write data in every byte lane whose enable is high. Lanes whose enable is low keep their value.
- R3: A write-once byte (offset 1, bytes 2:0, default 0) takes its first software write after reset. Every later write to that byte has no effect until the lane's lock is reset.
- R4: The write-once lock is held separately for each byte lane. Writing one lane of a write-once field locks only that lane, and the other lanes stay writable.
- R5: A write-one-to-clear bit (offset 2, default 0) clears when software writes a one to it. Writing a zero leaves it unchanged. A high `hw_set` bit sets it.
- R6: Sticky bits keep their value through a hard reset: offset 1 byte 2, offset 2 bits 31:16, and offset 3 bits 31:16. They return to their defaults only while `por_n` is low. Offset 3 byte 3 defaults to 0x3C.
- R7: Reserved bits (offset 1, byte 3, value 0xA5) never change when software writes them.
- R8: When `hw_set` and a software write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: Read data appears on `bus_rdata` one clock after the offset is presented. A read changes no bit of any attribute.
- R10: A non-sticky write-once lane is unlocked by a hard reset. The sticky write-once lane (offset 1, byte 2) stays locked through a hard reset and is unlocked only by power-good.
- R11: An offset at or above the number of words reads back as zero. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| por_n | input | 1 | Power-good, low resets every bit including sticky ones |
| bus_addr | input | AW | Word offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hw_set | input | NREG*32 | Per-bit set for write-one-to-clear bits |
| hw_load | input | NREG*32 | Per-bit load strobe for read-only bits |
| hw_val | input | NREG*32 | Per-bit value loaded into read-only bits |

## Verification
The bench builds the bank with NREG=4 and AW=3. This puts exactly one copy of every attribute type into the bank, and it leaves offsets 4 to 7 as unmapped space that can be read and written. With the two reset inputs driven separately, the bench can check sticky bits and sticky write-once locks across a hard reset on its own and then across a power-good loss. Per-cycle agreement with a behavioural model covers the one-cycle read latency and shows that reads have no side effects.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam int WORD_W      = 32;
  localparam int LANES       = 4;
  localparam int ATTR_W      = 4;
  localparam int LAYOUT_REGS = 4;

  typedef enum logic [ATTR_W-1:0] {
    ATT_RSV  = 4'd0,
    ATT_RO   = 4'd1,
    ATT_RW   = 4'd2,
    ATT_RWO  = 4'd3,
    ATT_RC   = 4'd4,
    ATT_ROS  = 4'd5,
    ATT_RWS  = 4'd6,
    ATT_RCS  = 4'd7,
    ATT_RWOS = 4'd8
  } attr_e;

  function automatic logic is_sticky(logic [ATTR_W-1:0] a);
    return (a == ATT_ROS) || (a == ATT_RWS) || (a == ATT_RCS) || (a == ATT_RWOS);
  endfunction

  function automatic logic is_write_once(logic [ATTR_W-1:0] a);
    return (a == ATT_RWO) || (a == ATT_RWOS);
  endfunction

  // Next value of one bit given its attribute and this cycle's events.
  function automatic logic cell_next(logic [ATTR_W-1:0] a, logic q, logic sw_we,
                                     logic sw_d, logic locked, logic hw_set,
                                     logic hw_load, logic hw_d);
    case (a)
      ATT_RO, ATT_ROS:    return hw_load ? hw_d : q;
      ATT_RW, ATT_RWS:    return sw_we ? sw_d : q;
      ATT_RWO, ATT_RWOS:  return (sw_we && !locked) ? sw_d : q;
      ATT_RC, ATT_RCS:    return hw_set ? 1'b1 : ((sw_we && sw_d) ? 1'b0 : q);
      default:            return q;
    endcase
  endfunction

  function automatic attr_e layout_code(int r, int i);
    case (r % LAYOUT_REGS)
      0:       return ATT_RW;
      1:       return (i < 16) ? ATT_RWO : ((i < 24) ? ATT_RWOS : ATT_RSV);
      2:       return (i < 16) ? ATT_RC : ATT_RCS;
      default: return (i < 16) ? ATT_RO : ((i < 24) ? ATT_ROS : ATT_RWS);
    endcase
  endfunction

  function automatic logic [LAYOUT_REGS*WORD_W*ATTR_W-1:0] layout_attr();
    logic [LAYOUT_REGS*WORD_W*ATTR_W-1:0] t;
    t = '0;
    for (int r = 0; r < LAYOUT_REGS; r++)
      for (int i = 0; i < WORD_W; i++)
        t[(r*WORD_W+i)*ATTR_W +: ATTR_W] = layout_code(r, i);
    return t;
  endfunction

  localparam logic [LAYOUT_REGS*WORD_W*ATTR_W-1:0] LAYOUT_ATTR = layout_attr();
  localparam logic [LAYOUT_REGS*WORD_W-1:0] LAYOUT_DEF =
    {32'h3C5A00C3, 32'h00000000, 32'hA5000000, 32'h12345678};
endpackage

// File: rtl/cab_bit.sv
module cab_bit
  import cab_pkg::*;
#(
  parameter logic [ATTR_W-1:0] CODE = ATT_RW,
  parameter logic DEF = 1'b0
) (
  input  logic clk,
  input  logic core_rst_n,
  input  logic por_n,
  input  logic sw_we,
  input  logic sw_d,
  input  logic locked,
  input  logic hw_set,
  input  logic hw_load,
  input  logic hw_d,
  output logic q
);
  localparam logic STICKY = is_sticky(CODE);

  logic nxt;
  assign nxt = cell_next(CODE, q, sw_we, sw_d, locked, hw_set, hw_load, hw_d);

  wire unused_cell_inputs = ^{sw_we, sw_d, locked, hw_set, hw_load, hw_d, nxt, por_n};

  generate
    if (CODE == ATT_RSV) begin : g_rsv
      assign q = DEF;
    end else if (STICKY) begin : g_sticky
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) q <= DEF;
        else if (core_rst_n) q <= nxt;
    end else begin : g_plain
      always_ff @(posedge clk or negedge core_rst_n)
        if (!core_rst_n) q <= DEF;
        else q <= nxt;
    end

    if (CODE == ATT_RO || CODE == ATT_ROS) begin : g_chk_ro
      assert_ro_sw_ignored_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
        !hw_load |=> $stable(q));
    end
    if (CODE == ATT_RW || CODE == ATT_RWS) begin : g_chk_rw
      assert_rw_takes_write_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
        sw_we |=> (q == $past(sw_d)));
    end
    if (CODE == ATT_RWO || CODE == ATT_RWOS) begin : g_chk_wo
      assert_wo_locked_hold_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
        locked |=> $stable(q));
    end
    if (CODE == ATT_RC || CODE == ATT_RCS) begin : g_chk_rc
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
        hw_set |=> q);
      assert_rc_clear_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (sw_we && sw_d && !hw_set) |=> !q);
      assert_rc_zero_hold_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (!hw_set && !(sw_we && sw_d)) |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/cab_lock.sv
module cab_lock #(
  parameter logic WO = 1'b1,
  parameter logic STICKY = 1'b0
) (
  input  logic clk,
  input  logic core_rst_n,
  input  logic por_n,
  input  logic lane_we,
  output logic locked
);
  wire unused_lock_inputs = ^{lane_we, por_n, clk};

  generate
    if (!WO) begin : g_none
      assign locked = 1'b0;
    end else begin : g_wo
      if (STICKY) begin : g_sticky
        always_ff @(posedge clk or negedge por_n)
          if (!por_n) locked <= 1'b0;
          else if (core_rst_n && lane_we) locked <= 1'b1;
      end else begin : g_plain
        always_ff @(posedge clk or negedge core_rst_n)
          if (!core_rst_n) locked <= 1'b0;
          else if (lane_we) locked <= 1'b1;
      end
      assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
        lane_we |=> locked);
      assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
        locked |=> locked);
    end
  endgenerate
endmodule

// File: rtl/cab_attr_bank.sv
module cab_attr_bank
  import cab_pkg::*;
#(
  parameter int NREG = LAYOUT_REGS,
  parameter int AW = $clog2(NREG) + 1,
  parameter logic [NREG*WORD_W*ATTR_W-1:0] ATTR = {(NREG/LAYOUT_REGS){LAYOUT_ATTR}},
  parameter logic [NREG*WORD_W-1:0] DEFV = {(NREG/LAYOUT_REGS){LAYOUT_DEF}}
) (
  input  logic                   clk,
  input  logic                   hrst_n,
  input  logic                   por_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_we,
  input  logic [LANES-1:0]       bus_be,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [NREG*WORD_W-1:0] hw_set,
  input  logic [NREG*WORD_W-1:0] hw_load,
  input  logic [NREG*WORD_W-1:0] hw_val
);
  localparam int LANE_W = WORD_W / LANES;

  function automatic logic lane_flag(int r, int b, logic need_sticky);
    logic [ATTR_W-1:0] c;
    for (int k = 0; k < LANE_W; k++) begin
      c = ATTR[((r*WORD_W) + b*LANE_W + k)*ATTR_W +: ATTR_W];
      if (is_write_once(c) && (!need_sticky || is_sticky(c))) return 1'b1;
    end
    return 1'b0;
  endfunction

  logic core_rst_n;
  assign core_rst_n = hrst_n & por_n;

  logic [NREG*WORD_W-1:0] bank_q;
  logic [NREG-1:0] reg_hit;
  logic addr_mapped;
  assign addr_mapped = (int'(bus_addr) < NREG);

  genvar r, b, k;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      assign reg_hit[r] = bus_we && (int'(bus_addr) == r);
      for (b = 0; b < LANES; b++) begin : g_lane
        localparam logic LANE_WO = lane_flag(r, b, 1'b0);
        localparam logic LANE_STICKY = lane_flag(r, b, 1'b1);
        logic lane_we;
        logic lane_locked;
        assign lane_we = reg_hit[r] & bus_be[b];

        cab_lock #(.WO(LANE_WO), .STICKY(LANE_STICKY)) u_lock (
          .clk(clk), .core_rst_n(core_rst_n), .por_n(por_n),
          .lane_we(lane_we), .locked(lane_locked));

        for (k = 0; k < LANE_W; k++) begin : g_bit
          localparam int IDX = r*WORD_W + b*LANE_W + k;
          cab_bit #(.CODE(ATTR[IDX*ATTR_W +: ATTR_W]), .DEF(DEFV[IDX])) u_bit (
            .clk(clk), .core_rst_n(core_rst_n), .por_n(por_n),
            .sw_we(lane_we), .sw_d(bus_wdata[b*LANE_W+k]), .locked(lane_locked),
            .hw_set(hw_set[IDX]), .hw_load(hw_load[IDX]), .hw_d(hw_val[IDX]),
            .q(bank_q[IDX]));
        end
      end
    end
  endgenerate

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_mapped && int'(bus_addr) == i) rd_word = bank_q[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) bus_rdata <= '0;
    else bus_rdata <= rd_word;

  assert_unmapped_read_zero_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    !addr_mapped |=> (bus_rdata == '0));
  assert_unmapped_write_inert_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_we && !addr_mapped && hw_set == '0 && hw_load == '0) |=> $stable(bank_q));
  assert_read_no_side_effect_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!bus_we && hw_set == '0 && hw_load == '0) |=> $stable(bank_q));
endmodule

// File: tb/cab_attr_bank_tb.sv
module cab_attr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AWB = 3;

  logic clk = 1'b0;
  logic hrst_n = 1'b0, por_n = 1'b0;
  logic [AWB-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NR*32-1:0] hw_set = '0, hw_load = '0, hw_val = '0;

  int checks = 0, failures = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cab_attr_bank #(.NREG(NR), .AW(AWB)) dut_i (
    .clk(clk), .hrst_n(hrst_n), .por_n(por_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_set(hw_set), .hw_load(hw_load), .hw_val(hw_val));

  // Reference model: kinds 0 rsv,1 ro,2 rw,3 wo,4 w1c,5 ro sticky,6 rw sticky,7 w1c sticky,8 wo sticky
  function automatic int kind(int r, int i);
    if (r == 0) return 2;
    if (r == 1) return (i >= 24) ? 0 : ((i >= 16) ? 8 : 3);
    if (r == 2) return (i >= 16) ? 7 : 4;
    return (i >= 24) ? 6 : ((i >= 16) ? 5 : 1);
  endfunction
  function automatic bit sticky(int k); return k >= 5; endfunction
  function automatic logic [31:0] defw(int r);
    case (r) 0: return 32'h12345678; 1: return 32'hA5000000; 2: return 32'h0; default: return 32'h3C5A00C3; endcase
  endfunction

  logic [31:0] m [NR];
  bit lk [NR][4];
  logic [31:0] exp_rd;

  always @(posedge clk) begin
    if (!por_n) begin
      for (int r = 0; r < NR; r++) begin
        m[r] = defw(r);
        for (int b = 0; b < 4; b++) lk[r][b] = 0;
      end
      exp_rd = 0;
    end else if (!hrst_n) begin
      for (int r = 0; r < NR; r++) begin
        for (int i = 0; i < 32; i++) if (!sticky(kind(r, i))) m[r][i] = defw(r) >> i;
        for (int b = 0; b < 3; b++) if (r == 1 && b != 2) lk[r][b] = 0;
      end
      exp_rd = 0;
    end else begin
      logic [31:0] nm [NR];
      exp_rd = (bus_addr < NR) ? m[bus_addr] : 32'h0;
      for (int r = 0; r < NR; r++) begin
        nm[r] = m[r];
        for (int i = 0; i < 32; i++) begin
          int k; bit w; int g;
          k = kind(r, i); g = r*32 + i;
          w = bus_we && (bus_addr == r) && bus_be[i/8];
          if ((k == 1 || k == 5) && hw_load[g]) nm[r][i] = hw_val[g];
          if ((k == 2 || k == 6) && w) nm[r][i] = bus_wdata[i];
          if ((k == 3 || k == 8) && w && !lk[r][i/8]) nm[r][i] = bus_wdata[i];
          if (k == 4 || k == 7) begin
            if (w && bus_wdata[i]) nm[r][i] = 1'b0;
            if (hw_set[g]) nm[r][i] = 1'b1;
          end
        end
      end
      for (int r = 0; r < NR; r++) begin
        m[r] = nm[r];
        for (int b = 0; b < 3; b++)
          if (r == 1 && bus_we && bus_addr == 1 && bus_be[b]) lk[r][b] = 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (run_cmp && hrst_n && por_n) check("R9 per-cycle model", bus_rdata, exp_rd);

  task automatic cyc(int a, bit we, logic [3:0] be, logic [31:0] d,
                     logic [NR*32-1:0] s, logic [NR*32-1:0] ld, logic [NR*32-1:0] v);
    @(negedge clk); #1;
    bus_addr = AWB'(a); bus_we = we; bus_be = be; bus_wdata = d;
    hw_set = s; hw_load = ld; hw_val = v;
    @(negedge clk); #1;
    bus_we = 0; bus_be = '0; hw_set = '0; hw_load = '0;
  endtask
  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    cyc(a, 1, be, d, '0, '0, '0);
  endtask
  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk); #1; bus_addr = AWB'(a); bus_we = 0;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask
  task automatic pulse_hard();
    @(negedge clk); #1; hrst_n = 0;
    @(negedge clk); #1; hrst_n = 1;
  endtask
  task automatic pulse_por();
    @(negedge clk); #1; por_n = 0;
    @(negedge clk); #1; por_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; por_n = 1; hrst_n = 1; run_cmp = 1;
    rd(0, 32'h12345678, "R2 reset default");
    rd(1, 32'hA5000000, "R7 reset default");
    rd(2, 32'h00000000, "R5 reset default");
    rd(3, 32'h3C5A00C3, "R1 reset default");
    rd(5, 32'h0, "R11 unmapped read");
    wr(0, 32'hDEADBEEF, 4'hF);
    rd(0, 32'hDEADBEEF, "R2 full write");
    wr(0, 32'h00005500, 4'b0010);
    rd(0, 32'hDEAD55EF, "R2 single lane");
    wr(3, 32'hFFFFFFFF, 4'hF);
    rd(3, 32'hFF5A00C3, "R1 sw write ignored");
    cyc(3, 0, 4'h0, 0, '0, {32'h00FFFFFF, 96'h0}, {32'h00771111, 96'h0});
    rd(3, 32'hFF771111, "R1 hw load");
    wr(1, 32'h00000011, 4'b0001);
    rd(1, 32'hA5000011, "R3 first write");
    wr(1, 32'h00002222, 4'b0011);
    rd(1, 32'hA5002211, "R4 per-lane lock");
    wr(1, 32'hFFFFFFFF, 4'hF);
    rd(1, 32'hA5FF2211, "R7 reserved kept");
    wr(1, 32'h00000000, 4'hF);
    rd(1, 32'hA5FF2211, "R3 later write blocked");
    cyc(2, 0, 4'h0, 0, {32'h0, 32'hFFFFFFFF, 64'h0}, '0, '0);
    rd(2, 32'hFFFFFFFF, "R5 hw set");
    wr(2, 32'h0000000F, 4'b0001);
    rd(2, 32'hFFFFFFF0, "R5 write one clears");
    wr(2, 32'h00000000, 4'hF);
    rd(2, 32'hFFFFFFF0, "R5 write zero holds");
    cyc(2, 1, 4'b0001, 32'h00000011, {32'h0, 32'h00000001, 64'h0}, '0, '0);
    rd(2, 32'hFFFFFFE1, "R8 set wins");
    rd(2, 32'hFFFFFFE1, "R9 repeated read");
    pulse_hard();
    rd(0, 32'h12345678, "R6 plain rw after hard reset");
    rd(1, 32'hA5FF0000, "R6 sticky wo byte kept");
    rd(2, 32'hFFFF0000, "R6 sticky clear bits kept");
    rd(3, 32'hFF7700C3, "R6 sticky ro/rw kept");
    wr(1, 32'h00333333, 4'hF);
    rd(1, 32'hA5FF3333, "R10 plain lock freed, sticky lock kept");
    wr(5, 32'hFFFFFFFF, 4'hF);
    rd(0, 32'h12345678, "R11 unmapped write inert");
    rd(1, 32'hA5FF3333, "R11 unmapped write inert");
    pulse_por();
    rd(2, 32'h00000000, "R6 power-good default");
    rd(3, 32'h3C5A00C3, "R6 power-good default");
    wr(1, 32'h00440000, 4'b0100);
    rd(1, 32'hA5440000, "R10 sticky lock freed by power-good");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*50000);
    failures++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule